// File: doc/BRIEF.md
# Duty-Cycle Bus Master Word Engine

This block is the master-side word engine of a two-wire sensor bus. On a start strobe it takes a parallel command word and sends it as a train of duty-cycle-coded bits on a three-level output code. An external line driver turns that code into bus voltages. Each bit time is divided into three equal slots, and the value of a bit is carried by how many of those slots the line spends low.

A word on the line has three parts in order: one bit time of porch at the signal-high level, the bits themselves with the most significant bit first, and a return to the idle level. While the word goes out, the block also samples a synchronized current-sense comparator once per bit time. From those samples it assembles the slave's reply to the previous command, so transmit and receive happen in the same word.

After each word the block stays busy for a programmable inter-frame gap before it accepts the next start. This gap gives slaves time to recharge between words. CRC generation and all analog functions lie outside the block.

Top module: `dcb_master`

## Requirements
- R1: After reset, and at any time `busy` is low, `level` is idle (2'b11). After reset `done` is 0 and `reply_word` is 0.
- R2: A `start` seen while `busy` is low is accepted at that clock edge, and `busy` rises. From the next cycle `level` is signal-high (2'b10) for three slots of S cycles each. S is `slot_div`, and a value of 0 counts as 1.
- R3: Each bit lasts three slots and begins with signal-low (2'b01). A 0 bit is low for two slots and then high for one slot. A 1 bit is low for one slot and then high for two slots.
- R4: Bits go out from `cmd_word[N-1]` down to `cmd_word[0]`, where N is the effective word length. Bits of `cmd_word` at N and above are ignored.
- R5: The effective word length N is `word_len` limited to the range MIN_BITS..MAX_BITS (8..24 by default). A smaller value sends 8 bits and a larger value sends 24 bits.
- R6: In the cycle right after the last slot of the last bit, `level` returns to idle and `done` is high for exactly one cycle.
- R7: `sense_in` is sampled in the last clock cycle of each bit time. The samples are shifted in first-bit-first, so the first sample ends up in bit N-1 and the last sample in bit 0, with zeros above bit N-1. `reply_word` takes the new value in the `done` cycle and holds it until the next `done`.
- R8: `busy` stays high through the `done` cycle and for `gap_cycles` cycles after it. It is low in the following cycle.
- R9: A `start` while `busy` is high is ignored. The waveform, timing and reply of the word in progress do not change, and no extra word follows.
- R10: `cmd_word`, `word_len`, `slot_div` and `gap_cycles` are captured when a start is accepted. Changes to these inputs during a word have no effect on that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to send one word |
| cmd_word | input | MAX_BITS | Command word, right-aligned |
| word_len | input | LEN_W | Number of bits to send (clamped to 8..24) |
| slot_div | input | SLOT_W | Clock cycles per slot (a bit time is three slots) |
| gap_cycles | input | GAP_W | Minimum idle cycles after the done cycle |
| sense_in | input | 1 | Synchronized reply current comparator, 1 = current drawn |
| level | output | 2 | Line level code: 11 idle, 10 signal-high, 01 signal-low |
| reply_word | output | MAX_BITS | Received reply, right-aligned |
| done | output | 1 | One-cycle pulse at the end of a word |
| busy | output | 1 | Word or inter-frame gap in progress |

## Verification
The bench builds the block with MAX_BITS=24, MIN_BITS=8, SLOT_W=3 and GAP_W=3. With these narrow widths, a sweep can cover every slot length from 0 to 3 (0 acting as 1), several gaps up to the 3-bit maximum of 7, and word lengths both inside and outside the clamp range. Every cycle of every word is then compared against a waveform computed in the bench. All-zero, all-one, alternating and mixed command and reply patterns are used, and a stray start with changed settings is injected in the middle of each word.

// File: rtl/dcb_pkg.sv
package dcb_pkg;

    // Line level code presented to the external driver.
    typedef enum logic [1:0] {
        LVL_LOW  = 2'b01,
        LVL_HIGH = 2'b10,
        LVL_IDLE = 2'b11
    } level_e;

    // Word sequencing phases.
    typedef enum logic [1:0] {
        PH_READY = 2'b00,
        PH_PORCH = 2'b01,
        PH_BITS  = 2'b10,
        PH_GAP   = 2'b11
    } phase_e;

    localparam logic [1:0] LAST_SLOT = 2'd2;

    // Slot timing seen by the rest of the block.
    typedef struct packed {
        logic [1:0] idx;
        logic       bit_end;
    } tick_t;

    // Level inside a bit: slot 0 always low, slot 2 always high,
    // slot 1 carries the value.
    function automatic level_e bit_level(input logic [1:0] idx, input logic val);
        level_e lv;
        case (idx)
            2'd0:    lv = LVL_LOW;
            2'd1:    lv = val ? LVL_HIGH : LVL_LOW;
            default: lv = LVL_HIGH;
        endcase
        return lv;
    endfunction

endpackage

// File: rtl/dcb_slot_timer.sv
module dcb_slot_timer
    import dcb_pkg::*;
#(
    parameter int SLOT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [SLOT_W-1:0] slot_len,
    output tick_t             tick
);
    localparam logic [SLOT_W-1:0] S_ONE = SLOT_W'(1);

    logic [SLOT_W-1:0] cnt_q;
    logic [1:0]        idx_q;
    logic              wrap;

    assign wrap = run && (cnt_q == slot_len - S_ONE);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            idx_q <= '0;
        end else if (wrap) begin
            cnt_q <= '0;
            idx_q <= (idx_q == LAST_SLOT) ? 2'd0 : idx_q + 2'd1;
        end else begin
            cnt_q <= cnt_q + S_ONE;
        end
    end

    assign tick.idx     = idx_q;
    assign tick.bit_end = wrap && (idx_q == LAST_SLOT);

endmodule

// File: rtl/dcb_word_seq.sv
module dcb_word_seq
    import dcb_pkg::*;
#(
    parameter int LEN_W = 5,
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LEN_W-1:0] len_c,
    input  logic [GAP_W-1:0] gap_len,
    input  logic             bit_end,
    output phase_e           phase,
    output logic             accept,
    output logic             last_bit,
    output logic             done
);
    localparam logic [LEN_W-1:0] L_ONE = LEN_W'(1);
    localparam logic [GAP_W-1:0] G_ONE = GAP_W'(1);

    phase_e           ph_q;
    logic [LEN_W-1:0] left_q;
    logic [GAP_W-1:0] gap_q;
    logic             done_q;

    assign accept   = start && (ph_q == PH_READY);
    assign last_bit = (ph_q == PH_BITS) && bit_end && (left_q == L_ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_READY;
            left_q <= '0;
            gap_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= last_bit;
            case (ph_q)
                PH_READY: if (accept) begin
                    ph_q   <= PH_PORCH;
                    left_q <= len_c;
                end
                PH_PORCH: if (bit_end) ph_q <= PH_BITS;
                PH_BITS: if (bit_end) begin
                    if (left_q == L_ONE) begin
                        ph_q  <= PH_GAP;
                        gap_q <= gap_len;
                    end else begin
                        left_q <= left_q - L_ONE;
                    end
                end
                default: begin
                    if (gap_q == '0) ph_q <= PH_READY;
                    else             gap_q <= gap_q - G_ONE;
                end
            endcase
        end
    end

    assign phase = ph_q;
    assign done  = done_q;

endmodule

// File: rtl/dcb_bit_shifter.sv
module dcb_bit_shifter #(
    parameter int MAX_BITS = 24,
    parameter int LEN_W    = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                accept,
    input  logic [MAX_BITS-1:0] cmd_word,
    input  logic [LEN_W-1:0]    len_c,
    input  logic                shift_en,
    input  logic                last_bit,
    input  logic                sense_in,
    output logic                tx_bit,
    output logic [MAX_BITS-1:0] reply_word
);
    localparam logic [LEN_W-1:0] L_MAX = LEN_W'(MAX_BITS);

    logic [MAX_BITS-1:0] tx_q;
    logic [MAX_BITS-1:0] rx_q;
    logic [MAX_BITS-1:0] reply_q;
    logic [MAX_BITS-1:0] rx_next;

    assign rx_next = {rx_q[MAX_BITS-2:0], sense_in};

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q    <= '0;
            rx_q    <= '0;
            reply_q <= '0;
        end else begin
            if (accept) begin
                tx_q <= cmd_word << (L_MAX - len_c);
                rx_q <= '0;
            end else if (shift_en) begin
                tx_q <= {tx_q[MAX_BITS-2:0], 1'b0};
                rx_q <= rx_next;
            end
            if (last_bit) reply_q <= rx_next;
        end
    end

    assign tx_bit     = tx_q[MAX_BITS-1];
    assign reply_word = reply_q;

endmodule

// File: rtl/dcb_master.sv
module dcb_master
    import dcb_pkg::*;
#(
    parameter int MAX_BITS = 24,
    parameter int MIN_BITS = 8,
    parameter int SLOT_W   = 8,
    parameter int GAP_W    = 8,
    parameter int LEN_W    = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [MAX_BITS-1:0] cmd_word,
    input  logic [LEN_W-1:0]    word_len,
    input  logic [SLOT_W-1:0]   slot_div,
    input  logic [GAP_W-1:0]    gap_cycles,
    input  logic                sense_in,
    output logic [1:0]          level,
    output logic [MAX_BITS-1:0] reply_word,
    output logic                done,
    output logic                busy
);
    localparam logic [LEN_W-1:0] L_MIN = LEN_W'(MIN_BITS);
    localparam logic [LEN_W-1:0] L_MAX = LEN_W'(MAX_BITS);

    logic [LEN_W-1:0]  len_c;
    logic [SLOT_W-1:0] slot_q;
    logic [GAP_W-1:0]  gap_q;
    phase_e            phase;
    tick_t             tick;
    logic              accept;
    logic              last_bit;
    logic              tx_bit;
    logic              in_word;
    level_e            lvl;

    assign len_c = (word_len < L_MIN) ? L_MIN :
                   (word_len > L_MAX) ? L_MAX : word_len;

    // Timing settings held for the whole word.
    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= SLOT_W'(1);
            gap_q  <= '0;
        end else if (accept) begin
            slot_q <= (slot_div == '0) ? SLOT_W'(1) : slot_div;
            gap_q  <= gap_cycles;
        end
    end

    assign in_word = (phase == PH_PORCH) || (phase == PH_BITS);

    dcb_slot_timer #(.SLOT_W(SLOT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (in_word),
        .slot_len (slot_q),
        .tick     (tick)
    );

    dcb_word_seq #(.LEN_W(LEN_W), .GAP_W(GAP_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .len_c    (len_c),
        .gap_len  (gap_q),
        .bit_end  (tick.bit_end),
        .phase    (phase),
        .accept   (accept),
        .last_bit (last_bit),
        .done     (done)
    );

    dcb_bit_shifter #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .cmd_word   (cmd_word),
        .len_c      (len_c),
        .shift_en   ((phase == PH_BITS) && tick.bit_end),
        .last_bit   (last_bit),
        .sense_in   (sense_in),
        .tx_bit     (tx_bit),
        .reply_word (reply_word)
    );

    always_comb begin
        case (phase)
            PH_PORCH: lvl = LVL_HIGH;
            PH_BITS:  lvl = bit_level(tick.idx, tx_bit);
            default:  lvl = LVL_IDLE;
        endcase
    end

    assign level = lvl;
    assign busy  = (phase != PH_READY);

endmodule

// File: rtl/dcb_master_chk.sv
module dcb_master_chk #(
    parameter int MAX_BITS = 24
) (
    input logic                clk,
    input logic                rst,
    input logic                start,
    input logic                busy,
    input logic                done,
    input logic [1:0]          level,
    input logic [MAX_BITS-1:0] reply_word
);
    // R1
    a_r1_idle_when_free: assert property (@(posedge clk) disable iff (rst)
        !busy |-> level == 2'b11);

    // R2
    a_r2_porch_first: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> level == 2'b10);

    // R3
    a_r3_bit_ends_high: assert property (@(posedge clk) disable iff (rst)
        level == 2'b01 |=> level != 2'b11);

    // R6
    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    a_r6_done_at_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> (level == 2'b11 && busy));

    // R7
    a_r7_reply_held: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(reply_word));

    // R9
    a_r9_start_only_when_free: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

endmodule

bind dcb_master dcb_master_chk #(.MAX_BITS(MAX_BITS)) u_dcb_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .level      (level),
    .reply_word (reply_word)
);

// File: tb/test_dcb_master.sv
module test_dcb_master;
    localparam int MAXB = 24;
    localparam int MINB = 8;
    localparam int SW   = 3;
    localparam int GW   = 3;
    localparam int LW   = $clog2(MAXB + 1);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic [MAXB-1:0] cmd_word = '0;
    logic [LW-1:0]   word_len = '0;
    logic [SW-1:0]   slot_div = '0;
    logic [GW-1:0]   gap_cycles = '0;
    logic            sense_in = 1'b0;
    logic [1:0]      level;
    logic [MAXB-1:0] reply_word;
    logic            done;
    logic            busy;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;  // 250 MHz

    dcb_master #(.MAX_BITS(MAXB), .MIN_BITS(MINB), .SLOT_W(SW), .GAP_W(GW)) i_dcb_master (
        .clk(clk), .rst(rst), .start(start), .cmd_word(cmd_word), .word_len(word_len),
        .slot_div(slot_div), .gap_cycles(gap_cycles), .sense_in(sense_in),
        .level(level), .reply_word(reply_word), .done(done), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One word, checked in every cycle from acceptance until busy drops.
    task automatic run_word(input int n_in, input logic [MAXB-1:0] cmd, input logic [MAXB-1:0] rep,
                            input int s_in, input int g, input string tag);
        int n, s, bt, t_end, lvl_err, busy_err, done_err;
        logic [31:0] lvl_act, lvl_exp, busy_act, busy_exp;
        logic [MAXB-1:0] rep_exp;
        logic [1:0] e_lvl;
        logic bitv;
        logic rep_ok;
        n = (n_in < MINB) ? MINB : ((n_in > MAXB) ? MAXB : n_in);
        s = (s_in == 0) ? 1 : s_in;
        bt = 3 * s;
        t_end = bt * (n + 1);
        rep_exp = rep & MAXB'((32'd1 << n) - 1);
        lvl_err = 0; busy_err = 0; done_err = 0; rep_ok = 1'b1;
        lvl_act = 0; lvl_exp = 0; busy_act = 0; busy_exp = 0;
        @(negedge clk);
        cmd_word = cmd; word_len = LW'(n_in); slot_div = SW'(s_in); gap_cycles = GW'(g);
        start = 1'b1; sense_in = 1'b1;
        @(posedge clk);
        for (int c = 0; c <= t_end + g + 1; c++) begin
            @(negedge clk);
            start = 1'b0;
            // R9 R10: stray start with altered settings in mid-word
            if (c == 2) begin
                start = 1'b1; cmd_word = ~cmd; word_len = LW'(MAXB);
                slot_div = SW'(s + 1); gap_cycles = GW'(g + 1);
            end
            if (c < bt) e_lvl = 2'b10;
            else if (c < t_end) begin
                bitv = cmd[n - 1 - (c / bt - 1)];
                e_lvl = ((c % bt) < (bitv ? s : 2 * s)) ? 2'b01 : 2'b10;
            end else e_lvl = 2'b11;
            if (level !== e_lvl) begin
                if (lvl_err == 0) begin lvl_act = {30'd0, level}; lvl_exp = {30'd0, e_lvl}; end
                lvl_err++;
            end
            if (busy !== (c <= t_end + g)) begin
                if (busy_err == 0) begin busy_act = c; busy_exp = t_end + g + 1; end
                busy_err++;
            end
            if (done !== (c == t_end)) done_err++;
            if (c >= t_end && reply_word !== rep_exp) rep_ok = 1'b0;
            // Drive the reply bit belonging to the current bit time.
            if (c >= bt && c < t_end) sense_in = rep[n - 1 - (c / bt - 1)];
            else sense_in = c[0];
        end
        check(lvl_err == 0, {tag, " R2 R3 R4 R6 R9 R10 level"}, lvl_act, lvl_exp);
        check(busy_err == 0, {tag, " R8 R9 busy drop cycle"}, busy_act, busy_exp);
        check(done_err == 0, {tag, " R6 done pulse count errors"}, done_err, 0);
        check(rep_ok, {tag, " R7 reply"}, {8'd0, reply_word}, {8'd0, rep_exp});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [MAXB-1:0] cmd, rep;
        int n, g, k;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(level == 2'b11, "R1 idle level", {30'd0, level}, 32'd3);
        check(!busy && !done, "R1 busy/done low", {30'd0, busy, done}, 0);
        check(reply_word == '0, "R1 reply zero", {8'd0, reply_word}, 0);
        k = 0;
        for (int s = 0; s < 4; s++) begin
            for (int li = 0; li < 5; li++) begin
                for (int gi = 0; gi < 3; gi++) begin
                    n = (li == 0) ? 5 : (li == 1) ? 8 : (li == 2) ? 11 : (li == 3) ? 24 : 30;
                    g = (gi == 0) ? 0 : (gi == 1) ? 2 : 7;
                    case (k % 4)
                        0: begin cmd = '0;            rep = 24'hFFFFFF; end
                        1: begin cmd = 24'hFFFFFF;    rep = '0; end
                        2: begin cmd = 24'hAAAAAA;    rep = 24'h555555; end
                        default: begin
                            cmd = MAXB'(k * 32'h9E3779 + 32'h1234);
                            rep = MAXB'(k * 32'h7F4A7C ^ 32'hC3A5);
                        end
                    endcase
                    run_word(n, cmd, rep, s, g, (n < MINB || n > MAXB) ? "R5" : "");
                    k++;
                end
            end
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule